// File: doc/BRIEF.md
# Dual-Consumer Entropy Word Buffer

This block sits between an entropy word producer and two consumers. Each incoming 32-bit word, marked by a one-cycle push strobe, is steered to one of two small FIFOs. The first FIFO is drained by software through register reads. Each read returns the oldest word and removes it. The second FIFO feeds a hardware consumer over a valid/ready handshake. The software FIFO has fixed priority, so a busy hardware consumer cannot starve it. A word goes to the hardware FIFO only when the software FIFO is full. When both FIFOs are full, the word is discarded.

Software sees the occupancy of its FIFO and a status flag. The flag compares that occupancy against a programmable threshold, so a driver can poll the flag or use it as an interrupt source and then read a block of words. Faulty accesses cause a one-cycle error pulse. Such an access is a software read of an empty FIFO, or an internal push into a full FIFO.

Top module: `entropy_fifo_router`

## Requirements
- R1: After reset the software depth is 0, the status flag is low, hw_valid is low, fifo_err is low and sw_rdata is 0.
- R2: The software FIFO holds 4 words, and sw_depth reports its occupancy as an unsigned count from 0 to 4.
- R3: While sw_rd is high and the software FIFO is not empty, sw_rdata shows the oldest word in that same cycle, and the word is removed at the clock edge. Words come out in arrival order.
- R4: A read and a push in the same cycle, with the software FIFO holding 1 to 3 words, leave sw_depth unchanged and keep arrival order.
- R5: An incoming word goes to the software FIFO whenever its depth is below 4, even when the hardware FIFO has room.
- R6: An incoming word goes to the hardware FIFO only when the software depth is 4 at that cycle, including a cycle in which a software read also occurs.
- R7: hw_valid is high exactly when the hardware FIFO holds a word, and hw_data is its oldest word. A word leaves only on a cycle with hw_valid and hw_ready both high. While hw_ready is low, hw_valid and hw_data hold.
- R8: sw_avail is high when sw_thresh is between 1 and 4 and sw_depth is at least sw_thresh. A threshold of 0 keeps sw_avail low.
- R9: A word that arrives while both FIFOs hold 4 words is discarded. It changes neither FIFO and does not raise fifo_err.
- R10: A software read of an empty FIFO returns 0 on sw_rdata and raises fifo_err in the following cycle.
- R11: fifo_err is registered and lasts a single cycle for each error event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_push | input | 1 | Incoming word strobe |
| in_word | input | 32 | Incoming entropy word |
| sw_rd | input | 1 | Software read strobe (pops head) |
| sw_thresh | input | 3 | Software status threshold |
| sw_rdata | output | 32 | Head of software FIFO during a read, else 0 |
| sw_depth | output | 3 | Software FIFO occupancy |
| sw_avail | output | 1 | Occupancy at or above threshold |
| hw_valid | output | 1 | Hardware FIFO holds a word |
| hw_data | output | 32 | Head of hardware FIFO |
| hw_ready | input | 1 | Downstream accepts hw_data |
| fifo_err | output | 1 | One-cycle pulse on an access error |

## Verification
The bench targets the boundaries of routing. A push while the software FIFO is full and a read occurs in the same cycle must land in the hardware FIFO. A router that looked at post-read room would keep it in software, and the hardware FIFO would stay empty. A push while both FIFOs are full must vanish without any error pulse. A design that recorded it would show an extra hardware word or a spurious fifo_err. Threshold 0 and threshold 4 are checked at full occupancy, where an off-by-one compare either asserts early or never asserts. A combined read and push is checked against a depth that drifts. Back-pressure is checked against a head word that changes while hw_ready is low.

// File: rtl/efr_pkg.sv
package efr_pkg;
   typedef enum logic [1:0] {
      DST_NONE = 2'd0,
      DST_SW   = 2'd1,
      DST_HW   = 2'd2,
      DST_DROP = 2'd3
   } efr_dest_e;
endpackage

// File: rtl/efr_fifo.sv
module efr_fifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           push,
   input  logic [WIDTH-1:0]               wdata,
   input  logic                           pop,
   output logic [WIDTH-1:0]               head,
   output logic [$clog2(DEPTH+1)-1:0]     count,
   output logic                           full,
   output logic                           empty,
   output logic                           ovf_evt,
   output logic                           udf_evt
);
   localparam int  AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CW   = $clog2(DEPTH + 1);
   localparam bit  POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("efr_fifo: DEPTH must be at least 1");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("efr_fifo: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr, wptr_nx, rptr_nx;
   logic             do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign ovf_evt = push && full && !do_pop;
   assign udf_evt = pop && empty;
   assign head    = empty ? '0 : mem[rptr];

   generate
      if (POW2) begin : g_wrap_pow2
         assign wptr_nx = wptr + AW'(1);
         assign rptr_nx = rptr + AW'(1);
      end else begin : g_wrap_cmp
         assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
         assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wptr_nx;
         if (do_pop)  rptr <= rptr_nx;
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= wdata;
   end
endmodule

// File: rtl/efr_router.sv
module efr_router
   import efr_pkg::*;
(
   input  logic      in_push,
   input  logic      sw_full,
   input  logic      hw_full,
   output efr_dest_e dest
);
   always_comb begin
      if (!in_push)      dest = DST_NONE;
      else if (!sw_full) dest = DST_SW;
      else if (!hw_full) dest = DST_HW;
      else               dest = DST_DROP;
   end
endmodule

// File: rtl/efr_level_cmp.sv
module efr_level_cmp #(
   parameter int CW = 3
) (
   input  logic [CW-1:0] level,
   input  logic [CW-1:0] thresh,
   output logic          at_or_above
);
   generate
      if (CW < 1) begin : g_bad_cw
         $error("efr_level_cmp: CW must be at least 1");
      end
   endgenerate
   assign at_or_above = (thresh != '0) && (level >= thresh);
endmodule

// File: rtl/entropy_fifo_router.sv
module entropy_fifo_router
   import efr_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int SW_DEPTH = 4,
   parameter int HW_DEPTH = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_push,
   input  logic [WORD_W-1:0]             in_word,
   input  logic                          sw_rd,
   input  logic [$clog2(SW_DEPTH+1)-1:0] sw_thresh,
   output logic [WORD_W-1:0]             sw_rdata,
   output logic [$clog2(SW_DEPTH+1)-1:0] sw_depth,
   output logic                          sw_avail,
   output logic                          hw_valid,
   output logic [WORD_W-1:0]             hw_data,
   input  logic                          hw_ready,
   output logic                          fifo_err
);
   localparam int SW_CW = $clog2(SW_DEPTH + 1);
   localparam int HW_CW = $clog2(HW_DEPTH + 1);

   generate
      if (SW_DEPTH < 1 || HW_DEPTH < 1) begin : g_bad_depths
         $error("entropy_fifo_router: depths must be at least 1");
      end
   endgenerate

   efr_dest_e        dest;
   logic             sw_full, sw_empty, sw_ovf, sw_udf;
   logic             hw_full, hw_empty, hw_ovf, hw_udf;
   logic [SW_CW-1:0] sw_cnt;
   logic [HW_CW-1:0] hw_cnt;
   logic [WORD_W-1:0] sw_head;
   logic             hw_pop;
   logic             err_q;

   efr_router u_router (
      .in_push (in_push),
      .sw_full (sw_full),
      .hw_full (hw_full),
      .dest    (dest)
   );

   efr_fifo #(.WIDTH(WORD_W), .DEPTH(SW_DEPTH)) u_sw_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (dest == DST_SW),
      .wdata   (in_word),
      .pop     (sw_rd),
      .head    (sw_head),
      .count   (sw_cnt),
      .full    (sw_full),
      .empty   (sw_empty),
      .ovf_evt (sw_ovf),
      .udf_evt (sw_udf)
   );

   assign hw_pop = hw_ready && !hw_empty;

   efr_fifo #(.WIDTH(WORD_W), .DEPTH(HW_DEPTH)) u_hw_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (dest == DST_HW),
      .wdata   (in_word),
      .pop     (hw_pop),
      .head    (hw_data),
      .count   (hw_cnt),
      .full    (hw_full),
      .empty   (hw_empty),
      .ovf_evt (hw_ovf),
      .udf_evt (hw_udf)
   );

   efr_level_cmp #(.CW(SW_CW)) u_level (
      .level       (sw_cnt),
      .thresh      (sw_thresh),
      .at_or_above (sw_avail)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= sw_udf || sw_ovf || hw_ovf || hw_udf;
   end

   assign sw_rdata = (sw_rd && !sw_empty) ? sw_head : '0;
   assign sw_depth = sw_cnt;
   assign hw_valid = !hw_empty;
   assign fifo_err = err_q;
endmodule

// File: rtl/efr_checker.sv
module efr_checker #(
   parameter int WORD_W   = 32,
   parameter int SW_DEPTH = 4,
   parameter int HW_DEPTH = 4
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          in_push,
   input logic                          sw_rd,
   input logic [$clog2(SW_DEPTH+1)-1:0] sw_thresh,
   input logic [WORD_W-1:0]             sw_rdata,
   input logic [$clog2(SW_DEPTH+1)-1:0] sw_depth,
   input logic                          sw_avail,
   input logic                          hw_valid,
   input logic [WORD_W-1:0]             hw_data,
   input logic                          hw_ready,
   input logic                          fifo_err,
   input logic [$clog2(HW_DEPTH+1)-1:0] hw_cnt
);
   localparam int SW_CW = $clog2(SW_DEPTH + 1);
   localparam int HW_CW = $clog2(HW_DEPTH + 1);

   a_r2_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
      sw_depth <= SW_CW'(SW_DEPTH));

   a_r4_rd_push_depth: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_rd && in_push && sw_depth != '0 && sw_depth != SW_CW'(SW_DEPTH))
      |=> $stable(sw_depth));

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_valid && !hw_ready && !in_push) |=> (hw_valid && $stable(hw_data)));

   a_r8_thresh_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_thresh == '0) |-> !sw_avail);

   a_r9_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (in_push && !sw_rd && sw_depth == SW_CW'(SW_DEPTH)
       && hw_cnt == HW_CW'(HW_DEPTH) && !hw_ready) |=> !fifo_err);

   a_r10_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_rd && sw_depth == '0) |-> (sw_rdata == '0));

   a_r10_empty_err: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_rd && sw_depth == '0) |=> fifo_err);

   a_r11_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fifo_err) |-> $past(sw_rd && sw_depth == '0));
endmodule

bind entropy_fifo_router efr_checker #(
   .WORD_W(WORD_W), .SW_DEPTH(SW_DEPTH), .HW_DEPTH(HW_DEPTH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_push(in_push), .sw_rd(sw_rd),
   .sw_thresh(sw_thresh), .sw_rdata(sw_rdata), .sw_depth(sw_depth),
   .sw_avail(sw_avail), .hw_valid(hw_valid), .hw_data(hw_data),
   .hw_ready(hw_ready), .fifo_err(fifo_err), .hw_cnt(hw_cnt)
);

// File: tb/entropy_fifo_router_bench.sv
module entropy_fifo_router_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_push = 1'b0;
   logic [31:0] in_word = '0;
   logic        sw_rd = 1'b0;
   logic [2:0]  sw_thresh = 3'd0;
   logic [31:0] sw_rdata;
   logic [2:0]  sw_depth;
   logic        sw_avail;
   logic        hw_valid;
   logic [31:0] hw_data;
   logic        hw_ready = 1'b0;
   logic        fifo_err;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   entropy_fifo_router u_entropy_fifo_router (
      .clk(clk), .rst_n(rst_n), .in_push(in_push), .in_word(in_word),
      .sw_rd(sw_rd), .sw_thresh(sw_thresh), .sw_rdata(sw_rdata),
      .sw_depth(sw_depth), .sw_avail(sw_avail), .hw_valid(hw_valid),
      .hw_data(hw_data), .hw_ready(hw_ready), .fifo_err(fifo_err)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      chk(act === exp, tag, act, exp);
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic push(input logic [31:0] w);
      in_push = 1'b1;
      in_word = w;
      step();
      in_push = 1'b0;
   endtask

   task automatic read(output logic [31:0] w);
      sw_rd = 1'b1;
      #1 w = sw_rdata;
      step();
      sw_rd = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) step();
      eq("R1 depth", {29'd0, sw_depth}, 0);
      eq("R1 avail", {31'd0, sw_avail}, 0);
      eq("R1 hw_valid", {31'd0, hw_valid}, 0);
      eq("R1 err", {31'd0, fifo_err}, 0);
      eq("R1 rdata", sw_rdata, 0);
      rst_n = 1'b1;
      step();
   endtask

   task automatic t_order();
      logic [31:0] w;
      hw_ready = 1'b0;
      for (int i = 0; i < 4; i++) begin
         push(32'hA000_0000 + i);
         eq("R2 depth count", {29'd0, sw_depth}, i + 1);
      end
      eq("R5 sw priority hw empty", {31'd0, hw_valid}, 0);
      for (int i = 0; i < 4; i++) begin
         read(w);
         eq("R3 order", w, 32'hA000_0000 + i);
      end
      eq("R3 drained", {29'd0, sw_depth}, 0);
   endtask

   task automatic t_rd_push();
      logic [31:0] w;
      push(32'hB0);
      push(32'hB1);
      sw_rd = 1'b1; in_push = 1'b1; in_word = 32'hB2;
      #1 eq("R4 rdata head", sw_rdata, 32'hB0);
      step();
      sw_rd = 1'b0; in_push = 1'b0;
      eq("R4 depth kept", {29'd0, sw_depth}, 2);
      read(w); eq("R4 order 1", w, 32'hB1);
      read(w); eq("R4 order 2", w, 32'hB2);
   endtask

   task automatic t_thresh();
      logic [31:0] w;
      sw_thresh = 3'd3;
      for (int i = 0; i < 4; i++) begin
         eq("R8 thresh3", {31'd0, sw_avail}, (i >= 3) ? 1 : 0);
         push(32'hC0 + i);
      end
      eq("R8 thresh3 full", {31'd0, sw_avail}, 1);
      sw_thresh = 3'd0; #1;
      eq("R8 thresh0 low", {31'd0, sw_avail}, 0);
      sw_thresh = 3'd4; #1;
      eq("R8 thresh4 at 4", {31'd0, sw_avail}, 1);
      read(w);
      eq("R8 thresh4 at 3", {31'd0, sw_avail}, 0);
      sw_thresh = 3'd1; #1;
      eq("R8 thresh1 at 3", {31'd0, sw_avail}, 1);
      for (int i = 0; i < 3; i++) read(w);
      eq("R8 thresh1 at 0", {31'd0, sw_avail}, 0);
      sw_thresh = 3'd0;
   endtask

   task automatic t_hw_drop();
      logic [31:0] w;
      hw_ready = 1'b0;
      for (int i = 0; i < 4; i++) push(32'hD0 + i);
      for (int i = 0; i < 4; i++) begin
         push(32'hE0 + i);
         eq("R6 hw gets overflow", {31'd0, hw_valid}, 1);
      end
      push(32'hFF);
      eq("R9 no err on drop", {31'd0, fifo_err}, 0);
      eq("R9 sw depth", {29'd0, sw_depth}, 4);
      for (int i = 0; i < 3; i++) begin
         step();
         eq("R7 hold data", hw_data, 32'hE0);
      end
      hw_ready = 1'b1;
      for (int i = 0; i < 4; i++) begin
         #1 eq("R7 drain order", hw_data, 32'hE0 + i);
         step();
      end
      eq("R9 dropped word absent", {31'd0, hw_valid}, 0);
      hw_ready = 1'b0;
      for (int i = 0; i < 4; i++) begin
         read(w);
         eq("R9 sw unchanged", w, 32'hD0 + i);
      end
   endtask

   task automatic t_full_read_push();
      logic [31:0] w;
      for (int i = 0; i < 4; i++) push(32'h50 + i);
      sw_rd = 1'b1; in_push = 1'b1; in_word = 32'h77;
      #1 eq("R6 rdata head", sw_rdata, 32'h50);
      step();
      sw_rd = 1'b0; in_push = 1'b0;
      eq("R6 sw depth after", {29'd0, sw_depth}, 3);
      eq("R6 hw valid", {31'd0, hw_valid}, 1);
      eq("R6 hw data", hw_data, 32'h77);
      hw_ready = 1'b1;
      step();
      hw_ready = 1'b0;
      eq("R7 popped", {31'd0, hw_valid}, 0);
      for (int i = 1; i < 4; i++) begin
         read(w);
         eq("R6 sw order", w, 32'h50 + i);
      end
   endtask

   task automatic t_empty_read();
      logic [31:0] w;
      eq("R10 pre err", {31'd0, fifo_err}, 0);
      read(w);
      eq("R10 zero data", w, 0);
      eq("R10 err raised", {31'd0, fifo_err}, 1);
      step();
      eq("R11 err one cycle", {31'd0, fifo_err}, 0);
      eq("R10 depth stays 0", {29'd0, sw_depth}, 0);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      finish_run();
   end

   initial begin
      t_reset();
      t_order();
      t_rd_push();
      t_thresh();
      t_hw_drop();
      t_full_read_push();
      t_empty_read();
      repeat (2) step();
      finish_run();
   end
endmodule